// File: doc/BRIEF.md
# Dual-Enable Bidirectional Latched Transceiver

A two-port bidirectional transceiver with one storage register for each direction of transfer, A-to-B and B-to-A. Each direction has three active-low controls: a direction enable, a latch enable and an output enable. Together they decide whether that path passes its source port straight through, holds a stored word, or drives the destination port. The ports are shared inout buses with tri-state drivers. Each direction also brings out a drive indication, so a test can see whether the destination port is driven or released.

The block is synchronous. All controls and source data are sampled on the rising edge of `clk`. The direction enable appears in two places: it opens and closes the storage path, and it gates the output driver. So one control can freeze the stored word and release the bus in the same cycle. The two directions share no state and run at the same time. If both are set to drive, each port carries its own direction's stored word. These are plain control pins with no valid/ready handshake and no back-pressure: a word is taken whenever the storage path is open at a clock edge.

Top module: `dual_en_xcvr`

## Requirements
- R1: All controls are active-low, so 0 means asserted. While a direction's enable and latch enable are both 0 at a clock edge, that direction's store takes the source port value. If the driver is enabled, the destination port shows that value after this same edge, which is one cycle of latency.
- R2: When the latch enable goes from 0 to 1 while the direction enable stays 0, the store keeps the value sampled at the last edge where both were 0.
- R3: When the direction enable goes from 0 to 1 while the latch enable stays 0, the store keeps the value sampled at the last edge where both were 0.
- R4: While the direction enable or the latch enable is 1, changes on the source port do not change the stored value.
- R5: The destination port is driven, and its drive indication is 1, only after an edge at which both the direction enable and the output enable were 0. The driven value is the stored word.
- R6: When the output enable is 1, the destination port is released and its drive indication is 0. Loading through an open storage path still takes place while the port is released.
- R7: When the direction enable is 1, the destination port is released and its drive indication is 0, whatever the output enable is.
- R8: The two directions work independently. With both enabled, port B carries the A-to-B stored word and port A carries the B-to-A stored word.
- R9: A synchronous active-high `rst` clears both stored words to 0 and holds both drive indications at 0. The ports stay released until a direction is enabled after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_io | inout | W | Port A: source for A-to-B, destination for B-to-A |
| b_io | inout | W | Port B: source for B-to-A, destination for A-to-B |
| ab_en_n | input | 1 | A-to-B direction enable, active-low |
| ab_le_n | input | 1 | A-to-B latch enable, active-low |
| ab_oe_n | input | 1 | A-to-B output enable, active-low |
| ba_en_n | input | 1 | B-to-A direction enable, active-low |
| ba_le_n | input | 1 | B-to-A latch enable, active-low |
| ba_oe_n | input | 1 | B-to-A output enable, active-low |
| b_drive_o | output | 1 | 1 while port B is driven by the block |
| a_drive_o | output | 1 | 1 while port A is driven by the block |

## Verification
Every result has the same timing: the stored word, the drive indication and the driven port value all change at the first rising edge that samples the new controls or data, one cycle after the stimulus. The bench changes inputs one time unit after a rising edge, lets exactly one edge pass, and then samples one time unit later, well before the following edge. A value held by a closed path is read back by enabling the output over a later edge while the path stays closed. The bench never drives a port while the block may be driving it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Active-low control group for one direction of transfer
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/xcvr_gate.sv
module xcvr_gate
  import xcvr_pkg::*;
(
  input  dir_ctrl_t ctrl,
  output logic      load,
  output logic      drive_req
);
  // Storage gate is closed when either enable is high
  always_comb begin
    load      = ~(ctrl.en_n | ctrl.le_n);
    drive_req = ~(ctrl.en_n | ctrl.oe_n);
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         drive_req,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      drive <= 1'b0;
    end else begin
      if (load) q <= din;
      drive <= drive_req;
    end
  end

  // R9: reset clears storage and releases the port
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (q == '0 && !drive));

  // R1: open path takes the sampled input
  a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));

  // R4: closed path keeps its word
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R5: driver follows the request one cycle later
  a_r5_drive_on: assert property (@(posedge clk) disable iff (rst)
    drive_req |=> drive);

  // R6 / R7: any disabling control releases the port
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    !drive_req |=> !drive);
endmodule

// File: rtl/dual_en_xcvr.sv
module dual_en_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_en_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_en_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n,
  output logic         b_drive_o,
  output logic         a_drive_o
);
  dir_ctrl_t          ctrl  [NUM_DIR];
  logic [W-1:0]       src   [NUM_DIR];
  logic [W-1:0]       word  [NUM_DIR];
  logic [NUM_DIR-1:0] load;
  logic [NUM_DIR-1:0] dreq;
  logic [NUM_DIR-1:0] drv;

  always_comb begin
    ctrl[DIR_AB] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
    ctrl[DIR_BA] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
    src[DIR_AB]  = a_io;
    src[DIR_BA]  = b_io;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_gate u_gate (
      .ctrl      (ctrl[d]),
      .load      (load[d]),
      .drive_req (dreq[d])
    );
    xcvr_store #(.W(W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .load      (load[d]),
      .drive_req (dreq[d]),
      .din       (src[d]),
      .q         (word[d]),
      .drive     (drv[d])
    );
  end

  assign b_io      = drv[DIR_AB] ? word[DIR_AB] : {W{1'bz}};
  assign a_io      = drv[DIR_BA] ? word[DIR_BA] : {W{1'bz}};
  assign b_drive_o = drv[DIR_AB];
  assign a_drive_o = drv[DIR_BA];

  // R8: each direction's driver depends only on its own controls
  a_r8_indep_ab: assert property (@(posedge clk) disable iff (rst)
    (ab_en_n || ab_oe_n) |=> !b_drive_o);
  a_r8_indep_ba: assert property (@(posedge clk) disable iff (rst)
    (ba_en_n || ba_oe_n) |=> !a_drive_o);
endmodule

// File: tb/tb_dual_en_xcvr.sv
`timescale 1ns/1ps
module tb_dual_en_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic a_drv_en = 1'b0, b_drv_en = 1'b0;
  logic b_drive_o, a_drive_o;
  wire  [W-1:0] a_bus, b_bus;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  assign a_bus = a_drv_en ? a_drv : {W{1'bz}};
  assign b_bus = b_drv_en ? b_drv : {W{1'bz}};

  always #2 clk = ~clk;

  dual_en_xcvr #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_io(a_bus), .b_io(b_bus),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .b_drive_o(b_drive_o), .a_drive_o(a_drive_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    step(); step();
    check("R9 b released in reset", {7'd0, b_drive_o}, 8'h00);
    check("R9 a released in reset", {7'd0, a_drive_o}, 8'h00);
    rst = 1'b0;
    ab_en_n = 1'b0; ab_oe_n = 1'b0;  // latch closed, show store
    step();
    check("R9 ab store cleared", b_bus, 8'h00);
    check("R5 b driven", {7'd0, b_drive_o}, 8'h01);
    ab_en_n = 1'b1; ab_oe_n = 1'b1;
    step();
  endtask

  task automatic t_transparent();
    a_drv_en = 1'b1; a_drv = 8'h5A;
    ab_en_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b0;
    step();
    check("R1 pass 5A", b_bus, 8'h5A);
    a_drv = 8'hC3;
    step();
    check("R1 pass C3", b_bus, 8'hC3);
  endtask

  task automatic t_le_capture();
    a_drv = 8'h3C;
    step();
    ab_le_n = 1'b1; a_drv = 8'hFF;
    step();
    check("R2 le edge keeps 3C", b_bus, 8'h3C);
    a_drv = 8'h11;
    step();
    check("R4 hold against 11", b_bus, 8'h3C);
  endtask

  task automatic t_en_capture();
    ab_le_n = 1'b0; a_drv = 8'h77;
    step();
    check("R1 pass 77", b_bus, 8'h77);
    ab_en_n = 1'b1; a_drv = 8'h88;
    step();
    check("R7 en high releases b", {7'd0, b_drive_o}, 8'h00);
    ab_le_n = 1'b1; a_drv = 8'h99;
    step();
    ab_en_n = 1'b0;
    step();
    check("R3 en edge keeps 77", b_bus, 8'h77);
  endtask

  task automatic t_oe_hiz_load();
    ab_oe_n = 1'b1; ab_le_n = 1'b0; a_drv = 8'h42;
    step();
    check("R6 oe high releases b", {7'd0, b_drive_o}, 8'h00);
    ab_le_n = 1'b1; a_drv = 8'h00;
    step();
    ab_oe_n = 1'b0;
    step();
    check("R6 load while released", b_bus, 8'h42);
    ab_en_n = 1'b1; ab_oe_n = 1'b1; a_drv_en = 1'b0;
    step();
  endtask

  task automatic t_ba_transparent();
    b_drv_en = 1'b1; b_drv = 8'h66;
    ba_en_n = 1'b0; ba_le_n = 1'b0; ba_oe_n = 1'b0;
    step();
    check("R1 ba pass 66", a_bus, 8'h66);
    check("R8 ab stays off", {7'd0, b_drive_o}, 8'h00);
    ba_en_n = 1'b1; ba_oe_n = 1'b1;
    step();
  endtask

  task automatic t_independent();
    b_drv = 8'hE1; ba_en_n = 1'b0; ba_le_n = 1'b0; ba_oe_n = 1'b1;
    step();
    ba_le_n = 1'b1; b_drv_en = 1'b0;
    a_drv_en = 1'b1; a_drv = 8'h2D;
    ab_en_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b1;
    step();
    ab_le_n = 1'b1; a_drv_en = 1'b0;
    step();
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    step();
    check("R8 b shows ab word", b_bus, 8'h2D);
    check("R8 a shows ba word", a_bus, 8'hE1);
    check("R5 both driving", {6'd0, a_drive_o, b_drive_o}, 8'h03);
  endtask

  task automatic t_reset_again();
    rst = 1'b1;
    step();
    check("R9 release in reset", {6'd0, a_drive_o, b_drive_o}, 8'h00);
    rst = 1'b0;
    step();
    check("R9 ab cleared", b_bus, 8'h00);
    check("R9 ba cleared", a_bus, 8'h00);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_le_capture();
    t_en_capture();
    t_oe_hiz_load();
    t_ba_transparent();
    t_independent();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule